// File: doc/BRIEF.md
# Two-Row Key Matrix Scanner

This block reads a key matrix of sixteen source lines by two return lines. The source lines double as display segment drivers, so the matrix is scanned only while the display frame gives a reserved key slot. A frame strobe `slot_go` marks the start of each key slot. A sub-step tick `step_tick` paces the sources through the slot. One full scan takes two frames: the first slot walks sources 1 to 8, the second walks sources 9 to 16.

Every sample goes into a shadow store. The 32-bit word seen by the host is refreshed in a single cycle, and only once both frames of a scan are done. A host read therefore never mixes two scans. The two return bits of one source sit side by side, so each byte of the word covers four sources. The scan-enable flag is looked at only on a slot strobe. A scan never starts part way through a slot, and a scan whose enable goes away between its two frames is dropped.

The sequencer has four states:
- `KS_IDLE` waits for a strobe while enabled (transition *start*).
- `KS_DRIVE` drives one source per sub-step. The last tick of the first half leads to *pause*, and the last tick of the second half leads to *finish*.
- `KS_PAUSE` waits for the next strobe. From there it takes *resume* if enabled or *abandon* if not.
- `KS_COMMIT` copies the shadow to the host word and returns to idle (transition *publish*).

Top module: `keymat_scanner`

## Requirements
- R1: After reset `key_word` is all zeros and `src_drive` is all zeros.
- R2: A strobe with `scan_en` low starts nothing: `src_drive` stays zero. No source is driven unless a strobe was seen in a state waiting for one.
- R3: In the first slot of a scan, sources 1 to 8 (`src_drive` bits 0 to 7) are each driven alone, in ascending order. The first is driven from the cycle after the strobe, and the scan moves to the next source after each `step_tick`.
- R4: In the second slot, sources 9 to 16 (`src_drive` bits 8 to 15) are driven in the same way. Between the two slots `src_drive` is zero.
- R5: The return lines are sampled on the `step_tick` that ends a source's sub-step. For source s (0-based), `key_ret[0]` lands in `key_word[2s]` and `key_ret[1]` in `key_word[2s+1]`.
- R6: `key_word` changes only as a whole, one cycle after the final tick of the second slot. Its old value holds through the first slot and the gap between slots.
- R7: If `scan_en` is low at the strobe that would begin the second slot, the scan is abandoned. No source is driven and `key_word` keeps its old value.
- R8: A change of `scan_en` inside a slot has no effect on that slot. A strobe arriving while sources are being driven is ignored.
- R9: At most one source is driven at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_go | input | 1 | One-cycle strobe at the start of a frame's key slot |
| step_tick | input | 1 | One-cycle tick ending a source sub-step |
| scan_en | input | 1 | Scan enable, sampled only on `slot_go` |
| key_ret | input | 2 | Return lines; bit 0 is the first row |
| src_drive | output | 16 | One-hot source drive, bit s is source s+1 |
| key_word | output | 32 | Committed key data, two bits per source |

## Verification
The bench uses distinct key patterns, including one with only the lowest and highest bits set. A design that swapped the two rows, or packed the bits by row instead of by source, would return a wrong word. It samples `key_word` in the gap between slots, where a design that published early would show half a scan. It drops the enable before the second strobe, and a design that ignored that would drive sources and overwrite the word. It also toggles the enable and fires a stray strobe inside a slot: a sequencer that reacted to either would truncate or restart the walk.

// File: rtl/keymat_pkg.sv
package keymat_pkg;
    typedef enum logic [1:0] {
        KS_IDLE,
        KS_DRIVE,
        KS_PAUSE,
        KS_COMMIT
    } kscan_state_t;
endpackage

// File: rtl/keymat_seq.sv
module keymat_seq
    import keymat_pkg::*;
#(
    parameter int N_SRC   = 16,
    parameter int N_PHASE = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     slot_go,
    input  logic                     step_tick,
    input  logic                     scan_en,
    output logic                     drive_act,
    output logic [$clog2(N_SRC)-1:0] src_sel,
    output logic                     sample_en,
    output logic                     commit
);
    localparam int PER_PH = N_SRC / N_PHASE;
    localparam int SRC_W  = $clog2(N_SRC);
    localparam int IDX_W  = (PER_PH > 1) ? $clog2(PER_PH) : 1;
    localparam int PH_W   = (N_PHASE > 1) ? $clog2(N_PHASE) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PER_PH - 1);
    localparam logic [PH_W-1:0]  LAST_PH  = PH_W'(N_PHASE - 1);

    kscan_state_t     state, nxt;
    logic [IDX_W-1:0] idx;
    logic [PH_W-1:0]  phase;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= KS_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            KS_IDLE:   if (slot_go && scan_en) nxt = KS_DRIVE;
            KS_DRIVE:  if (step_tick && idx == LAST_IDX)
                           nxt = (phase == LAST_PH) ? KS_COMMIT : KS_PAUSE;
            KS_PAUSE:  if (slot_go) nxt = scan_en ? KS_DRIVE : KS_IDLE;
            KS_COMMIT: nxt = KS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx   <= '0;
            phase <= '0;
        end else if (state == KS_IDLE) begin
            idx   <= '0;
            phase <= '0;
        end else if (state == KS_DRIVE && step_tick) begin
            if (idx == LAST_IDX) begin
                idx   <= '0;
                phase <= phase + 1'b1;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end

    always_comb begin
        drive_act = (state == KS_DRIVE);
        sample_en = (state == KS_DRIVE) && step_tick;
        commit    = (state == KS_COMMIT);
        src_sel   = SRC_W'(phase) * SRC_W'(PER_PH) + SRC_W'(idx);
    end
endmodule

// File: rtl/keymat_srcdec.sv
module keymat_srcdec #(
    parameter int N_SRC = 16
) (
    input  logic                     drive_act,
    input  logic [$clog2(N_SRC)-1:0] src_sel,
    output logic [N_SRC-1:0]         src_drive
);
    localparam int SRC_W = $clog2(N_SRC);
    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        assign src_drive[g] = drive_act && (src_sel == SRC_W'(g));
    end
endmodule

// File: rtl/keymat_store.sv
module keymat_store #(
    parameter int N_SRC = 16,
    parameter int N_RET = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sample_en,
    input  logic [$clog2(N_SRC)-1:0] src_sel,
    input  logic [N_RET-1:0]         key_ret,
    input  logic                     commit,
    output logic [N_SRC*N_RET-1:0]   key_word
);
    localparam int SRC_W = $clog2(N_SRC);
    localparam int KEY_W = N_SRC * N_RET;

    logic [KEY_W-1:0] shadow;

    for (genvar g = 0; g < N_SRC; g++) begin : g_cell
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                shadow[g*N_RET +: N_RET] <= '0;
            else if (sample_en && src_sel == SRC_W'(g))
                shadow[g*N_RET +: N_RET] <= key_ret;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      key_word <= '0;
        else if (commit) key_word <= shadow;
    end
endmodule

// File: rtl/keymat_scanner.sv
module keymat_scanner #(
    parameter int N_SRC   = 16,
    parameter int N_RET   = 2,
    parameter int N_PHASE = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     slot_go,
    input  logic                     step_tick,
    input  logic                     scan_en,
    input  logic [N_RET-1:0]         key_ret,
    output logic [N_SRC-1:0]         src_drive,
    output logic [N_SRC*N_RET-1:0]   key_word
);
    localparam int SRC_W = $clog2(N_SRC);

    logic             drive_act;
    logic [SRC_W-1:0] src_sel;
    logic             sample_en;
    logic             commit_pulse;

    keymat_seq #(.N_SRC(N_SRC), .N_PHASE(N_PHASE)) u_seq (
        .clk(clk), .rst_n(rst_n), .slot_go(slot_go), .step_tick(step_tick),
        .scan_en(scan_en), .drive_act(drive_act), .src_sel(src_sel),
        .sample_en(sample_en), .commit(commit_pulse)
    );

    keymat_srcdec #(.N_SRC(N_SRC)) u_dec (
        .drive_act(drive_act), .src_sel(src_sel), .src_drive(src_drive)
    );

    keymat_store #(.N_SRC(N_SRC), .N_RET(N_RET)) u_store (
        .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .src_sel(src_sel),
        .key_ret(key_ret), .commit(commit_pulse), .key_word(key_word)
    );
endmodule

// File: rtl/keymat_scanner_chk.sv
module keymat_scanner_chk #(
    parameter int N_SRC = 16,
    parameter int KEY_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             slot_go,
    input logic [N_SRC-1:0] src_drive,
    input logic [KEY_W-1:0] key_word,
    input logic             commit_pulse
);
    // R9
    one_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(src_drive));

    // R6
    atomic_publish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (key_word != $past(key_word)) |-> $past(commit_pulse));

    // R2
    start_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(src_drive) == '0 && !$past(slot_go)) |-> (src_drive == '0));

    // R3
    ascending_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(src_drive) != '0 && src_drive != '0 && src_drive != $past(src_drive))
            |-> (src_drive == ($past(src_drive) << 1)));
endmodule

bind keymat_scanner keymat_scanner_chk #(.N_SRC(N_SRC), .KEY_W(N_SRC*N_RET)) u_chk (
    .clk(clk), .rst_n(rst_n), .slot_go(slot_go), .src_drive(src_drive),
    .key_word(key_word), .commit_pulse(commit_pulse)
);

// File: tb/keymat_scanner_bench.sv
module keymat_scanner_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slot_go = 1'b0;
    logic        step_tick = 1'b0;
    logic        scan_en = 1'b0;
    logic [1:0]  key_ret = 2'b00;
    logic [15:0] src_drive;
    logic [31:0] key_word;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    keymat_scanner u_keymat_scanner (
        .clk(clk), .rst_n(rst_n), .slot_go(slot_go), .step_tick(step_tick),
        .scan_en(scan_en), .key_ret(key_ret), .src_drive(src_drive),
        .key_word(key_word)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic strobe();
        @(negedge clk) slot_go = 1'b1;
        @(negedge clk) slot_go = 1'b0;
    endtask

    // One key slot: walks eight sources, optionally toggling enable or
    // firing a stray strobe mid-slot (R8).
    task automatic run_slot(input int half, input logic [31:0] keys,
                            input bit wiggle, input logic [31:0] old_word);
        strobe();
        for (int i = 0; i < 8; i++) begin
            int s = half * 8 + i;
            chk(half ? "R4 source order" : "R3 source order",
                {16'h0, src_drive}, 32'(1) << s);
            key_ret   = {keys[2*s+1], keys[2*s]};
            step_tick = 1'b1;
            if (wiggle && i == 3) begin
                scan_en = ~scan_en;
                slot_go = 1'b1;
            end
            @(negedge clk);
            step_tick = 1'b0;
            slot_go   = 1'b0;
            if (wiggle && i == 3) scan_en = ~scan_en;
        end
        if (half == 0) begin
            chk("R4 idle between slots", {16'h0, src_drive}, 32'h0);
            chk("R6 word held mid scan", key_word, old_word);
        end
    endtask

    task automatic full_scan(input logic [31:0] keys, input bit wiggle);
        logic [31:0] prev = key_word;
        scan_en = 1'b1;
        run_slot(0, keys, wiggle, prev);
        repeat (3) @(negedge clk);
        chk("R6 word held in gap", key_word, prev);
        run_slot(1, keys, 1'b0, prev);
        @(negedge clk);
        chk("R5 key word layout", key_word, keys);
        chk("R4 drive off after scan", {16'h0, src_drive}, 32'h0);
    endtask

    task automatic test_reset();
        chk("R1 reset word", key_word, 32'h0);
        chk("R1 reset drive", {16'h0, src_drive}, 32'h0);
    endtask

    task automatic test_no_enable();
        scan_en = 1'b0;
        strobe();
        for (int i = 0; i < 4; i++) begin
            chk("R2 no scan without enable", {16'h0, src_drive}, 32'h0);
            @(negedge clk);
        end
    endtask

    task automatic test_abandon();
        logic [31:0] prev = key_word;
        scan_en = 1'b1;
        run_slot(0, 32'h1234_5678, 1'b0, prev);
        scan_en = 1'b0;
        strobe();
        for (int i = 0; i < 4; i++) begin
            chk("R7 abandoned scan drives nothing", {16'h0, src_drive}, 32'h0);
            @(negedge clk);
        end
        chk("R7 abandoned scan keeps word", key_word, prev);
        scan_en = 1'b1;
        strobe();
        chk("R7 fresh scan starts at source 1", {16'h0, src_drive}, 32'h1);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk) step_tick = 1'b1;
            @(negedge clk) step_tick = 1'b0;
        end
        scan_en = 1'b0;
        strobe();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_no_enable();
        full_scan(32'hA5C3_1E96, 1'b0);
        full_scan(32'h8000_0001, 1'b0);
        test_abandon();
        full_scan(32'h6B2D_F047, 1'b1);   // R8 wiggle in first slot
        full_scan(32'h0000_0000, 1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule